// File: doc/BRIEF.md
# Accelerator-to-Host Bus Cycle Bridge

This block lets a fast 32-bit processor on an add-in card take the place of the resident processor of a slower host with a 16-bit bus. After reset it requests the host bus and holds the accelerator in reset until the host grants the bus. From then on, each accelerator access becomes one or two host word cycles. The host sees the same clocked sequence of cycle states that its own processor would produce.

The host clock is made inside the block by dividing the core clock. Each host cycle walks through eight half-clock states, S0 to S7. The address and direction are set up in S0. The address strobe and the data strobes assert together in S2. The sequence waits in S4 until the host acknowledge is seen at a half-clock boundary. Read data is captured at the end of S6, and the strobes negate in S7. Because the sequence is paced by the host clock, a fast accelerator cannot end one cycle and start the next before the host logic has seen it.

A 32-bit access is split in big-endian order: the upper half first, at the given address, then the lower half at the next word address. The accelerator is acknowledged only after the final host cycle is complete. Its read data stays stable until it drops its request.

Top module: `acc_host_bridge`

## Requirements
- R1: From reset until a bus grant (host_bg_n low) is seen, acc_rst_n stays low, host_drive stays low, and host_as_n, host_uds_n and host_lds_n stay high. Bus request host_br_n goes low in the first cycle after reset.
- R2: Once the grant is seen, acc_rst_n and host_drive go high and stay high, and host_br_n stays low.
- R3: A long access (acc_size 10 or 11) runs as two host word cycles, both with both data strobes. The first is at word address acc_addr[AW-1:1] and carries write bits 31:16. The second is at that address plus one and carries write bits 15:0. Read data is {first word, second word}.
- R4: A word access (acc_size 01) runs as one host cycle with both strobes. Write data comes from bits 15:0. Read data is the host word, zero-extended to 32 bits.
- R5: A byte access (acc_size 00) runs as one host cycle. UDS is asserted when acc_addr[0]=0 and LDS when acc_addr[0]=1. Write data bits 7:0 are driven on both byte lanes. The selected lane (15:8 for UDS, 7:0 for LDS) is returned in acc_rdata[7:0], and the upper bits are zero.
- R6: AS and the enabled data strobes assert together, and a data strobe is never asserted while AS is negated. Once asserted, they stay asserted until host_dtack_n is sampled low; each half-clock without an acknowledge adds a wait.
- R7: Between consecutive host cycles, host_as_n stays high for at least one full host clock (2*HALF_DIV core cycles), even for back-to-back accesses.
- R8: acc_ack asserts only after the last host cycle of the access has completed, with host_as_n high. It stays high, and acc_rdata stays stable, until acc_req is low.
- R9: host_clk has a period of 2*HALF_DIV core clock cycles and changes only at half-clock boundaries.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock, divided to make the host clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| acc_rst_n | output | 1 | Reset release to the accelerator |
| acc_req | input | 1 | Access request, held until acknowledged |
| acc_wr | input | 1 | 1 for write, 0 for read |
| acc_size | input | 2 | 00 byte, 01 word, 10/11 long |
| acc_addr | input | AW | Byte address |
| acc_wdata | input | 32 | Write data |
| acc_rdata | output | 32 | Read data |
| acc_ack | output | 1 | Access termination |
| host_clk | output | 1 | Generated host clock |
| host_br_n | output | 1 | Bus request to resident host processor |
| host_bg_n | input | 1 | Bus grant from resident host processor |
| host_drive | output | 1 | Bridge owns and drives the host bus |
| host_addr | output | AW-1 | Host word address |
| host_rw | output | 1 | 1 read, 0 write |
| host_as_n | output | 1 | Address strobe |
| host_uds_n | output | 1 | Upper data strobe |
| host_lds_n | output | 1 | Lower data strobe |
| host_dout | output | 16 | Host write data |
| host_dout_en | output | 1 | Host data output enable |
| host_din | input | 16 | Host read data |
| host_dtack_n | input | 1 | Host cycle acknowledge |

## Verification
The assertions check on every cycle the properties that hold at all times. These are: the strobes stay quiet before the grant, the bus request is held once the accelerator runs, the data strobes are never asserted without AS, and the cycle waits in S4 while the acknowledge is high. They also check the minimum AS-negated gap before each new cycle, the host clock changing only at half-clock ticks, and read data staying stable while the termination is held. Some behaviour can only be shown by the bench scenarios: how accesses of each size split into host cycles, the word order and lane choice, the reassembled and zero-extended read data, the effect of writes seen in later reads, the host clock period, and correct operation under long acknowledge delays.

// File: rtl/hb_pkg.sv
package hb_pkg;
   localparam int HW  = 16;
   localparam int XW  = 2 * HW;
   localparam int BW  = HW / 2;

   typedef enum logic [3:0] {
      HS_IDLE, HS_S0, HS_S1, HS_S2, HS_S3, HS_S4, HS_S5, HS_S6, HS_S7
   } hstate_e;

   typedef enum logic [1:0] {
      AX_IDLE, AX_RUN, AX_DONE
   } axstate_e;
endpackage

// File: rtl/hb_timebase.sv
module hb_timebase #(
   parameter int HALF_DIV = 3
) (
   input  logic clk,
   input  logic rst_n,
   output logic tick,
   output logic host_clk
);
   localparam int CW = (HALF_DIV > 1) ? $clog2(HALF_DIV) : 1;

   logic [CW-1:0] cnt_q;

   assign tick = (cnt_q == CW'(HALF_DIV - 1));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt_q    <= '0;
         host_clk <= 1'b0;
      end else if (tick) begin
         cnt_q    <= '0;
         host_clk <= ~host_clk;
      end else begin
         cnt_q    <= cnt_q + 1'b1;
      end
   end

   // R9
   hclk_pace_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !tick |=> $stable(host_clk));
endmodule

// File: rtl/hb_arbiter.sv
module hb_arbiter #(
   parameter int BG_SYNC = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic bg_n,
   output logic br_n,
   output logic owned
);
   logic [BG_SYNC-1:0] sync_q;

   generate
      if (BG_SYNC == 1) begin : g_one
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) sync_q <= '1;
            else        sync_q <= bg_n;
         end
      end else begin : g_chain
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) sync_q <= '1;
            else        sync_q <= {sync_q[BG_SYNC-2:0], bg_n};
         end
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         br_n  <= 1'b1;
         owned <= 1'b0;
      end else begin
         br_n <= 1'b0;
         if (!br_n && !sync_q[BG_SYNC-1]) owned <= 1'b1;
      end
   end

   // R2
   own_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
      owned |=> owned && !br_n);
endmodule

// File: rtl/hb_seq.sv
module hb_seq
   import hb_pkg::*;
#(
   parameter int AW       = 24,
   parameter int HALF_DIV = 3
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          tick,
   input  logic          go,
   input  logic          wr,
   input  logic [AW-2:0] waddr,
   input  logic [1:0]    lanes,
   input  logic [HW-1:0] wdata,
   input  logic          dtack_n,
   input  logic [HW-1:0] din,
   output logic          done,
   output logic [HW-1:0] rdata,
   output logic [AW-2:0] addr,
   output logic          rw,
   output logic          as_n,
   output logic          uds_n,
   output logic          lds_n,
   output logic [HW-1:0] dout,
   output logic          dout_en
);
   localparam int GAP_MIN = 2 * HALF_DIV;
   localparam int GW      = $clog2(GAP_MIN + 1);

   hstate_e    st;
   logic       wr_l;
   logic [1:0] lanes_l;
   logic [GW-1:0] gap_q;

   assign done = (st == HS_S7) && tick;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st      <= HS_IDLE;
         as_n    <= 1'b1;
         uds_n   <= 1'b1;
         lds_n   <= 1'b1;
         rw      <= 1'b1;
         addr    <= '0;
         dout    <= '0;
         dout_en <= 1'b0;
         rdata   <= '0;
         wr_l    <= 1'b0;
         lanes_l <= 2'b00;
      end else if (tick) begin
         case (st)
            HS_IDLE: if (go) begin
               st      <= HS_S0;
               addr    <= waddr;
               rw      <= ~wr;
               wr_l    <= wr;
               lanes_l <= lanes;
               dout    <= wdata;
            end
            HS_S0: st <= HS_S1;
            HS_S1: begin
               st      <= HS_S2;
               as_n    <= 1'b0;
               uds_n   <= ~lanes_l[1];
               lds_n   <= ~lanes_l[0];
               dout_en <= wr_l;
            end
            HS_S2: st <= HS_S3;
            HS_S3: st <= HS_S4;
            HS_S4: if (!dtack_n) st <= HS_S5;
            HS_S5: st <= HS_S6;
            HS_S6: begin
               st    <= HS_S7;
               rdata <= din;
               as_n  <= 1'b1;
               uds_n <= 1'b1;
               lds_n <= 1'b1;
            end
            HS_S7: begin
               st      <= HS_IDLE;
               rw      <= 1'b1;
               dout_en <= 1'b0;
            end
            default: st <= HS_IDLE;
         endcase
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                      gap_q <= '0;
      else if (!as_n)                  gap_q <= '0;
      else if (gap_q < GW'(GAP_MIN))   gap_q <= gap_q + 1'b1;
   end

   // R6
   dtack_wait_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (st == HS_S4 && tick && dtack_n) |=> (st == HS_S4 && !as_n));

   // R6
   strobe_pair_chk: assert property (@(posedge clk) disable iff (!rst_n)
      as_n |-> (uds_n && lds_n));

   // R7
   as_gap_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!as_n && $past(as_n)) |-> (gap_q >= GW'(GAP_MIN)));
endmodule

// File: rtl/acc_host_bridge.sv
module acc_host_bridge
   import hb_pkg::*;
#(
   parameter int AW       = 24,
   parameter int HALF_DIV = 3,
   parameter int BG_SYNC  = 2
) (
   input  logic          clk,
   input  logic          rst_n,
   output logic          acc_rst_n,
   input  logic          acc_req,
   input  logic          acc_wr,
   input  logic [1:0]    acc_size,
   input  logic [AW-1:0] acc_addr,
   input  logic [31:0]   acc_wdata,
   output logic [31:0]   acc_rdata,
   output logic          acc_ack,
   output logic          host_clk,
   output logic          host_br_n,
   input  logic          host_bg_n,
   output logic          host_drive,
   output logic [AW-2:0] host_addr,
   output logic          host_rw,
   output logic          host_as_n,
   output logic          host_uds_n,
   output logic          host_lds_n,
   output logic [15:0]   host_dout,
   output logic          host_dout_en,
   input  logic [15:0]   host_din,
   input  logic          host_dtack_n
);
   initial begin
      if (HALF_DIV < 1 || AW < 4 || BG_SYNC < 1 || BG_SYNC > 3 || HW != 16)
         $fatal(1, "acc_host_bridge: parameter out of range");
   end

   logic          tick;
   logic          owned;
   axstate_e      ax_st;
   logic          wr_q;
   logic [1:0]    size_q;
   logic [AW-1:0] addr_q;
   logic [XW-1:0] wdata_q;
   logic          idx_q;
   logic [HW-1:0] hi_q;
   logic [XW-1:0] rdata_q;

   logic          seq_go, seq_done;
   logic [AW-2:0] seq_waddr;
   logic [1:0]    seq_lanes;
   logic [HW-1:0] seq_wdata, seq_rdata;
   logic          is_long, is_byte;

   hb_timebase #(.HALF_DIV(HALF_DIV)) u_tb (
      .clk(clk), .rst_n(rst_n), .tick(tick), .host_clk(host_clk));

   hb_arbiter #(.BG_SYNC(BG_SYNC)) u_arb (
      .clk(clk), .rst_n(rst_n), .bg_n(host_bg_n),
      .br_n(host_br_n), .owned(owned));

   assign acc_rst_n  = owned;
   assign host_drive = owned;

   assign is_long = size_q[1];
   assign is_byte = (size_q == 2'b00);
   assign seq_go  = (ax_st == AX_RUN);
   assign seq_waddr = addr_q[AW-1:1] + (AW-1)'(idx_q);

   always_comb begin
      if (is_byte) begin
         seq_lanes = addr_q[0] ? 2'b01 : 2'b10;
         seq_wdata = {wdata_q[BW-1:0], wdata_q[BW-1:0]};
      end else if (is_long) begin
         seq_lanes = 2'b11;
         seq_wdata = idx_q ? wdata_q[HW-1:0] : wdata_q[XW-1:HW];
      end else begin
         seq_lanes = 2'b11;
         seq_wdata = wdata_q[HW-1:0];
      end
   end

   hb_seq #(.AW(AW), .HALF_DIV(HALF_DIV)) u_seq (
      .clk(clk), .rst_n(rst_n), .tick(tick), .go(seq_go),
      .wr(wr_q), .waddr(seq_waddr), .lanes(seq_lanes), .wdata(seq_wdata),
      .dtack_n(host_dtack_n), .din(host_din),
      .done(seq_done), .rdata(seq_rdata),
      .addr(host_addr), .rw(host_rw), .as_n(host_as_n),
      .uds_n(host_uds_n), .lds_n(host_lds_n),
      .dout(host_dout), .dout_en(host_dout_en));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ax_st   <= AX_IDLE;
         wr_q    <= 1'b0;
         size_q  <= 2'b00;
         addr_q  <= '0;
         wdata_q <= '0;
         idx_q   <= 1'b0;
         hi_q    <= '0;
         rdata_q <= '0;
      end else begin
         case (ax_st)
            AX_IDLE: if (acc_req && owned) begin
               ax_st   <= AX_RUN;
               wr_q    <= acc_wr;
               size_q  <= acc_size;
               addr_q  <= acc_addr;
               wdata_q <= acc_wdata;
               idx_q   <= 1'b0;
            end
            AX_RUN: if (seq_done) begin
               if (is_long && !idx_q) begin
                  idx_q <= 1'b1;
                  hi_q  <= seq_rdata;
               end else begin
                  ax_st <= AX_DONE;
                  if (!wr_q) begin
                     if (is_long)
                        rdata_q <= {hi_q, seq_rdata};
                     else if (is_byte)
                        rdata_q <= {{(XW-BW){1'b0}},
                                    addr_q[0] ? seq_rdata[BW-1:0] : seq_rdata[HW-1:BW]};
                     else
                        rdata_q <= {{(XW-HW){1'b0}}, seq_rdata};
                  end
               end
            end
            AX_DONE: if (!acc_req) ax_st <= AX_IDLE;
            default: ax_st <= AX_IDLE;
         endcase
      end
   end

   assign acc_ack   = (ax_st == AX_DONE);
   assign acc_rdata = rdata_q;

   // R1
   quiet_before_grant_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !acc_rst_n |-> (host_as_n && host_uds_n && host_lds_n));

   // R2
   br_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      acc_rst_n |-> !host_br_n);

   // R8
   ack_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
      acc_ack |-> host_as_n);

   // R8
   rdata_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (acc_ack && $past(acc_ack)) |-> $stable(acc_rdata));

   // R8
   ack_until_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (acc_ack && acc_req) |=> acc_ack);
endmodule

// File: tb/acc_host_bridge_bench.sv
module acc_host_bridge_bench;
   localparam int AW = 24;
   localparam int HD = 3;
   localparam int PER = 20;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   always #(PER/2) clk = ~clk;

   logic        acc_rst_n, acc_req, acc_wr, acc_ack;
   logic [1:0]  acc_size;
   logic [AW-1:0] acc_addr;
   logic [31:0] acc_wdata, acc_rdata;
   logic        host_clk, host_br_n, host_bg_n, host_drive;
   logic [AW-2:0] host_addr;
   logic        host_rw, host_as_n, host_uds_n, host_lds_n, host_dout_en;
   logic [15:0] host_dout, host_din;
   logic        host_dtack_n;

   acc_host_bridge #(.AW(AW), .HALF_DIV(HD), .BG_SYNC(2)) u_acc_host_bridge (
      .clk(clk), .rst_n(rst_n), .acc_rst_n(acc_rst_n), .acc_req(acc_req),
      .acc_wr(acc_wr), .acc_size(acc_size), .acc_addr(acc_addr),
      .acc_wdata(acc_wdata), .acc_rdata(acc_rdata), .acc_ack(acc_ack),
      .host_clk(host_clk), .host_br_n(host_br_n), .host_bg_n(host_bg_n),
      .host_drive(host_drive), .host_addr(host_addr), .host_rw(host_rw),
      .host_as_n(host_as_n), .host_uds_n(host_uds_n), .host_lds_n(host_lds_n),
      .host_dout(host_dout), .host_dout_en(host_dout_en), .host_din(host_din),
      .host_dtack_n(host_dtack_n));

   int checks = 0;
   int errors = 0;

   // host-side model
   logic [15:0] mem [256];
   logic        prev_as;
   int          hi_cnt, lo_cnt, last_lo, min_gap, ncyc, dly;
   logic [22:0] log_addr [64];
   logic [1:0]  log_lane [64];

   assign host_dtack_n = !(!host_as_n && lo_cnt >= dly);
   assign host_din = (!host_as_n && host_rw) ? mem[host_addr[7:0]] : 16'h0000;

   always @(posedge clk) begin
      if (!rst_n) begin
         for (int i = 0; i < 256; i++) mem[i] <= {i[7:0], ~i[7:0]};
         prev_as <= 1'b1; hi_cnt <= 0; lo_cnt <= 0; last_lo <= 0;
         min_gap <= 1000000; ncyc <= 0;
      end else begin
         prev_as <= host_as_n;
         if (host_as_n) begin hi_cnt <= hi_cnt + 1; lo_cnt <= 0; end
         else begin hi_cnt <= 0; lo_cnt <= lo_cnt + 1; end
         if (prev_as && !host_as_n) begin
            if (ncyc > 0 && hi_cnt < min_gap) min_gap <= hi_cnt;
            log_addr[ncyc % 64] <= host_addr;
            log_lane[ncyc % 64] <= {!host_uds_n, !host_lds_n};
            ncyc <= ncyc + 1;
         end
         if (!prev_as && host_as_n) last_lo <= lo_cnt;
         if (!host_as_n && !host_rw && !host_dtack_n) begin
            if (!host_uds_n) mem[host_addr[7:0]][15:8] <= host_dout[15:8];
            if (!host_lds_n) mem[host_addr[7:0]][7:0]  <= host_dout[7:0];
         end
      end
   end

   task automatic chk(input bit ok, input string req, input logic [31:0] act,
                      input logic [31:0] exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   task automatic summary();
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   endtask

   task automatic do_access(input bit wr, input logic [1:0] sz, input logic [7:0] a,
                            input logic [31:0] wd, output logic [31:0] rd,
                            output int ncy, output int first);
      int t;
      first = ncyc;
      @(negedge clk);
      acc_wr = wr; acc_size = sz; acc_addr = {16'h0, a}; acc_wdata = wd; acc_req = 1'b1;
      t = 0;
      while (!acc_ack && t < 20000) begin @(negedge clk); t++; end
      chk(t < 20000, "R8 termination arrives", t, 0);
      ncy = ncyc - first;
      chk(host_as_n == 1'b1, "R8 host idle at termination", {31'h0, host_as_n}, 1);
      rd = acc_rdata;
      for (int k = 0; k < 3; k++) begin
         @(negedge clk);
         chk(acc_rdata == rd && acc_ack, "R8 rdata and ack held", acc_rdata, rd);
      end
      acc_req = 1'b0;
      t = 0;
      while (acc_ack && t < 100) begin @(negedge clk); t++; end
   endtask

   // {wr, size, addr, wdata, expected read}
   localparam logic [74:0] VEC [12] = '{
      {1'b0, 2'b10, 8'h10, 32'h0,        32'h08F709F6},
      {1'b0, 2'b01, 8'h12, 32'h0,        32'h000009F6},
      {1'b0, 2'b00, 8'h14, 32'h0,        32'h0000000A},
      {1'b0, 2'b00, 8'h15, 32'h0,        32'h000000F5},
      {1'b1, 2'b10, 8'h20, 32'h12345678, 32'h0},
      {1'b0, 2'b10, 8'h20, 32'h0,        32'h12345678},
      {1'b1, 2'b00, 8'h31, 32'h000000AB, 32'h0},
      {1'b0, 2'b01, 8'h30, 32'h0,        32'h000018AB},
      {1'b1, 2'b00, 8'h40, 32'h0000005C, 32'h0},
      {1'b0, 2'b01, 8'h40, 32'h0,        32'h00005CDF},
      {1'b1, 2'b01, 8'h50, 32'h0000BEEF, 32'h0},
      {1'b0, 2'b10, 8'h50, 32'h0,        32'hBEEF29D6}
   };

   initial begin
      #(PER * 200000);
      checks++; errors++;
      $display("FAIL watchdog expired actual=%0d expected=0", 1);
      summary();
   end

   initial begin
      logic [31:0] rd;
      int ncy, first;
      time t0, t1;
      acc_req = 1'b0; acc_wr = 1'b0; acc_size = 2'b00; acc_addr = '0;
      acc_wdata = '0; host_bg_n = 1'b1; dly = 2;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      repeat (20) @(negedge clk);
      // R1: no grant yet
      chk(acc_rst_n == 1'b0, "R1 accelerator held in reset", {31'h0, acc_rst_n}, 0);
      chk(host_br_n == 1'b0, "R1 bus requested", {31'h0, host_br_n}, 0);
      chk(host_drive == 1'b0, "R1 host bus not driven", {31'h0, host_drive}, 0);
      chk(host_as_n && host_uds_n && host_lds_n, "R1 strobes negated",
          {29'h0, host_as_n, host_uds_n, host_lds_n}, 32'h7);
      // R9: host clock period
      @(posedge host_clk); t0 = $time;
      @(posedge host_clk); t1 = $time;
      chk((t1 - t0) == 2 * HD * PER, "R9 host clock period", 32'(t1 - t0), 2 * HD * PER);
      @(negedge clk);
      host_bg_n = 1'b0;
      repeat (8) @(negedge clk);
      chk(acc_rst_n == 1'b1, "R2 accelerator released", {31'h0, acc_rst_n}, 1);
      chk(host_br_n == 1'b0 && host_drive, "R2 bus kept",
          {30'h0, host_br_n, host_drive}, 32'h1);

      for (int v = 0; v < 12; v++) begin
         logic        w;
         logic [1:0]  s;
         logic [7:0]  a;
         logic [1:0]  exp_lane;
         int          exp_n;
         string       tag;
         w = VEC[v][74]; s = VEC[v][73:72]; a = VEC[v][71:64];
         exp_n = s[1] ? 2 : 1;
         exp_lane = (s == 2'b00) ? (a[0] ? 2'b01 : 2'b10) : 2'b11;
         tag = s[1] ? "R3" : ((s == 2'b01) ? "R4" : "R5");
         do_access(w, s, a, VEC[v][63:32], rd, ncy, first);
         chk(ncy == exp_n, {tag, " host cycle count"}, ncy, exp_n);
         chk(log_addr[first % 64] == {15'h0, a[7:1]}, {tag, " first word address"},
             {9'h0, log_addr[first % 64]}, {25'h0, a[7:1]});
         chk(log_lane[first % 64] == exp_lane, {tag, " data strobes"},
             {30'h0, log_lane[first % 64]}, {30'h0, exp_lane});
         if (s[1])
            chk(log_addr[(first + 1) % 64] == {15'h0, a[7:1]} + 23'd1, "R3 second word at A+2",
                {9'h0, log_addr[(first + 1) % 64]}, {25'h0, a[7:1]} + 32'd1);
         if (!w)
            chk(rd == VEC[v][31:0], {tag, " read data"}, rd, VEC[v][31:0]);
      end

      // R6: long acknowledge delay inserts waits
      dly = 30;
      do_access(1'b0, 2'b10, 8'h10, 32'h0, rd, ncy, first);
      chk(rd == 32'h08F709F6, "R6 read with wait states", rd, 32'h08F709F6);
      chk(last_lo >= 30, "R6 strobes held until acknowledge", last_lo, 30);
      chk(ncy == 2, "R8 both cycles before termination", ncy, 2);
      dly = 2;

      // R7: back-to-back accesses keep the gap
      do_access(1'b0, 2'b01, 8'h02, 32'h0, rd, ncy, first);
      chk(rd == 32'h000001FE, "R4 back-to-back read", rd, 32'h000001FE);
      do_access(1'b0, 2'b01, 8'h04, 32'h0, rd, ncy, first);
      chk(rd == 32'h000002FD, "R4 back-to-back read", rd, 32'h000002FD);
      chk(min_gap >= 2 * HD, "R7 AS negated gap", min_gap, 2 * HD);

      summary();
   end
endmodule